// File: doc/BRIEF.md
# Eight-bit compare-match timer

This block is an 8-bit up-counter with a compare unit that drives one waveform pin. It advances once for each cycle in which the count-enable tick is high. A mode field selects between two counting schemes. In free-running mode the counter passes through every value and wraps. In clear-on-compare mode the compare value is the top of the count, so the period is the compare value plus one tick.

On each real compare match the block sets a compare flag. It also applies a selectable action to the pin: none, toggle, clear or set. A force strobe applies that action at once without a match. The flags are sticky: only hardware sets them and only an acknowledge clears them. Software writes the counter, the compare value and a control word through a simple write port. The block has no data stream. Every pin is a plain control or status signal with no handshake and no back-pressure.

Top module: `cmp_timer8`

## Requirements
- R1: When the mode field holds 0, each tick adds one to the counter, and 0xFF is followed by 0x00. No compare match ever clears the counter in this mode.
- R2: The overflow flag rises with the tick that takes the counter from 0xFF to 0x00. It then stays high until a cycle with `ack_ovf_i` high clears it.
- R3: When the mode field holds 2, a tick taken while the counter equals the compare value returns the counter to 0x00. The counter repeats a cycle of compare+1 ticks.
- R4: On a compare match, the action field selects what happens to `wave_o`. 0 leaves the pin unchanged, 1 toggles it, 2 drives it to 0 and 3 drives it to 1. The field value in force at the match is the one used.
- R5: The action field has no influence on the sequence of counter values.
- R6: A high `force_i` applies the selected action to `wave_o` in the next cycle, with or without a tick. A forced compare sets no flag and does not clear the counter.
- R7: A compare match is a tick with the counter equal to the compare value. It sets the compare flag, which holds until `ack_cmp_i` clears it. A match in the same cycle as the acknowledge leaves the flag set.
- R8: Software may write the counter in any mode, and the write takes priority over a tick in the same cycle. The first tick after a counter write produces no compare match.
- R9: After reset the counter, the compare value, the mode and action fields, both flags and `wave_o` are all 0.
- R10: Mode field values other than 0 and 2 behave exactly like mode 0.
- R11: In a cycle with `tick_i` low and no counter write, the counter holds its value.
- R12: Write select 0 targets the counter and 1 targets the compare value. Select 2 targets the control word: mode in data bits 2:0 and action in data bits 5:4. Select 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable (prescaled timer tick) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 counter, 1 compare, 2 control |
| wr_data_i | input | 8 | Write data |
| force_i | input | 1 | Force-compare strobe |
| ack_ovf_i | input | 1 | Clears the overflow flag |
| ack_cmp_i | input | 1 | Clears the compare flag |
| count_o | output | 8 | Current counter value |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_flag_o | output | 1 | Compare-match flag |
| wave_o | output | 1 | Waveform pin |

## Verification
The hardest case to reach from the ports is the blocked match. Software writes the counter to a value equal to the compare value, and the very next tick must neither set the flag, nor move the pin, nor clear the counter in clear-on-compare mode. The stimulus loads the compare register first, then writes the counter to the same value, and ticks once. It checks that the counter moved on by one with no flag set. It then writes one value below the compare value and ticks twice, to show that the real match still arrives. Two further sequences are built on purpose. One raises the acknowledge in the same cycle as a match tick. The other raises the force strobe while the tick is low.

// File: rtl/cmp_timer8_pkg.sv
package cmp_timer8_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } wave_act_e;

  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_CONTROL = 2'd2,
    SEL_NONE    = 2'd3
  } wr_sel_e;

  localparam int unsigned MODE_W   = 3;
  localparam int unsigned MODE_CTC = 2;
  localparam int unsigned ACT_LSB  = 4;
endpackage

// File: rtl/cmp_timer8_regs.sv
module cmp_timer8_regs
  import cmp_timer8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] cmp_val_o,
  output logic             ctc_o,
  output wave_act_e        act_o,
  output logic             wr_cnt_o
);
  logic [WIDTH-1:0]  cmp_q;
  logic [MODE_W-1:0] mode_q;
  wave_act_e         act_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      mode_q <= '0;
      act_q  <= ACT_NONE;
    end else if (wr_en_i) begin
      case (wr_sel_e'(wr_sel_i))
        SEL_COMPARE: cmp_q <= wr_data_i;
        SEL_CONTROL: begin
          mode_q <= wr_data_i[MODE_W-1:0];
          act_q  <= wave_act_e'(wr_data_i[ACT_LSB +: 2]);
        end
        default: ;
      endcase
    end
  end

  assign cmp_val_o = cmp_q;
  assign ctc_o     = (mode_q == MODE_W'(MODE_CTC));
  assign act_o     = act_q;
  assign wr_cnt_o  = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_COUNT);

  AST_CMP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i == 2'd1) |=> $stable(cmp_q)); // R12
endmodule

// File: rtl/cmp_timer8_counter.sv
module cmp_timer8_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_cnt_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [WIDTH-1:0] cmp_val_i,
  input  logic             ctc_i,
  output logic [WIDTH-1:0] count_o,
  output logic             match_o,
  output logic             wrap_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  logic [WIDTH-1:0] count_q;
  logic             block_q;
  logic             live_tick;

  assign live_tick = tick_i && !wr_cnt_i;
  assign match_o   = live_tick && !block_q && (count_q == cmp_val_i);
  assign wrap_o    = live_tick && (count_q == CNT_MAX);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      count_q <= '0;
      block_q <= 1'b0;
    end else if (wr_cnt_i) begin
      count_q <= wr_data_i;
      block_q <= 1'b1;
    end else if (tick_i) begin
      block_q <= 1'b0;
      if (ctc_i && match_o) count_q <= '0;
      else                  count_q <= count_q + 1'b1;
    end
  end

  assign count_o = count_q;

  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_tick && !(ctc_i && match_o)) |=> count_q == WIDTH'($past(count_q) + 1'b1)); // R1
  AST_CTC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctc_i && match_o) |=> count_q == '0); // R3
  AST_NO_MATCH_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> !match_o); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_cnt_i) |=> $stable(count_q)); // R11
endmodule

// File: rtl/cmp_timer8_flags.sv
module cmp_timer8_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic wrap_i,
  input  logic ack_ovf_i,
  input  logic ack_cmp_i,
  output logic ovf_flag_o,
  output logic cmp_flag_o
);
  logic ovf_q, cmp_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      if (wrap_i)         ovf_q <= 1'b1;
      else if (ack_ovf_i) ovf_q <= 1'b0;
      if (match_i)        cmp_q <= 1'b1;
      else if (ack_cmp_i) cmp_q <= 1'b0;
    end
  end

  assign ovf_flag_o = ovf_q;
  assign cmp_flag_o = cmp_q;

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ack_ovf_i) |=> ovf_q); // R2
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> ovf_q); // R2
  AST_CMP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> cmp_q); // R7
endmodule

// File: rtl/cmp_timer8_wave.sv
module cmp_timer8_wave
  import cmp_timer8_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      match_i,
  input  logic      force_i,
  input  wave_act_e act_i,
  output logic      wave_o
);
  logic wave_q, apply;

  assign apply = match_i || force_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wave_q <= 1'b0;
    end else if (apply) begin
      case (act_i)
        ACT_TOGGLE: wave_q <= ~wave_q;
        ACT_CLEAR:  wave_q <= 1'b0;
        ACT_SET:    wave_q <= 1'b1;
        default:    wave_q <= wave_q;
      endcase
    end
  end

  assign wave_o = wave_q;

  AST_NONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_NONE) |=> $stable(wave_q)); // R4
  AST_FORCE_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && act_i == ACT_TOGGLE) |=> wave_q != $past(wave_q)); // R6
  AST_SET_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply && act_i == ACT_SET) |=> wave_q); // R4
endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
  import cmp_timer8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             force_i,
  input  logic             ack_ovf_i,
  input  logic             ack_cmp_i,
  output logic [WIDTH-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             cmp_flag_o,
  output logic             wave_o
);
  logic [WIDTH-1:0] cmp_val;
  logic             ctc, wr_cnt, match, wrap;
  wave_act_e        act;

  cmp_timer8_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .cmp_val_o(cmp_val), .ctc_o(ctc), .act_o(act),
    .wr_cnt_o(wr_cnt)
  );

  cmp_timer8_counter #(.WIDTH(WIDTH)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_cnt_i(wr_cnt),
    .wr_data_i(wr_data_i), .cmp_val_i(cmp_val), .ctc_i(ctc),
    .count_o(count_o), .match_o(match), .wrap_o(wrap)
  );

  cmp_timer8_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .match_i(match), .wrap_i(wrap),
    .ack_ovf_i(ack_ovf_i), .ack_cmp_i(ack_cmp_i),
    .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o)
  );

  cmp_timer8_wave u_wave (
    .clk_i(clk_i), .rst_ni(rst_ni), .match_i(match), .force_i(force_i),
    .act_i(act), .wave_o(wave_o)
  );

  AST_FORCE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && !tick_i && !cmp_flag_o) |=> !cmp_flag_o); // R6
endmodule

// File: tb/cmp_timer8_tb_top.sv
module cmp_timer8_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0, force_s = 1'b0;
  logic       ack_ovf = 1'b0, ack_cmp = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] count;
  logic       ovf_flag, cmp_flag, wave;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer8 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .force_i(force_s),
    .ack_ovf_i(ack_ovf), .ack_cmp_i(ack_cmp), .count_o(count),
    .ovf_flag_o(ovf_flag), .cmp_flag_o(cmp_flag), .wave_o(wave)
  );

  task automatic check(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk); wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic ack_all();
    @(negedge clk); ack_ovf = 1'b1; ack_cmp = 1'b1;
    @(negedge clk); ack_ovf = 1'b0; ack_cmp = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R9", "count", count, 0);
    check("R9", "ovf", ovf_flag, 0);
    check("R9", "cmp", cmp_flag, 0);
    check("R9", "wave", wave, 0);
    ticks(3);
    check("R9", "compare reset to 0: match on count 0", cmp_flag, 1);
  endtask

  task automatic t_normal_wrap();
    do_reset();
    write_reg(2'd0, 8'hFD);
    ticks(2);
    check("R1", "count before wrap", count, 8'hFF);
    check("R2", "ovf before wrap", ovf_flag, 0);
    ticks(1);
    check("R1", "count wraps", count, 0);
    check("R2", "ovf set on wrap", ovf_flag, 1);
    ticks(3);
    check("R1", "count after match, no clear", count, 3);
    check("R2", "ovf sticky", ovf_flag, 1);
    ack_all();
    check("R2", "ovf acked", ovf_flag, 0);
  endtask

  task automatic t_hold();
    do_reset();
    write_reg(2'd0, 8'h40);
    repeat (5) @(negedge clk);
    check("R11", "count held without tick", count, 8'h40);
    write_reg(2'd3, 8'h77);
    check("R12", "select 3 ignored (count)", count, 8'h40);
    ticks(1);
    check("R12", "select 3 ignored (no match)", cmp_flag, 0);
  endtask

  task automatic t_ctc();
    do_reset();
    write_reg(2'd2, 8'h02);
    write_reg(2'd1, 8'd5);
    write_reg(2'd0, 8'd0);
    ticks(5);
    check("R3", "count at top", count, 5);
    check("R7", "no flag before match", cmp_flag, 0);
    ticks(1);
    check("R3", "cleared after top", count, 0);
    check("R7", "flag on match", cmp_flag, 1);
    check("R2", "no ovf in short ctc", ovf_flag, 0);
    ticks(6);
    check("R3", "second period", count, 0);
  endtask

  task automatic t_actions();
    do_reset();
    write_reg(2'd2, 8'h12);
    write_reg(2'd1, 8'd5);
    write_reg(2'd0, 8'd0);
    ticks(6);
    check("R4", "toggle to 1", wave, 1);
    check("R5", "count unchanged by action", count, 0);
    ticks(6);
    check("R4", "toggle to 0", wave, 0);
    ticks(3);
    check("R5", "mid-period count", count, 3);
    write_reg(2'd2, 8'h32);
    check("R4", "no effect until match", wave, 0);
    ticks(3);
    check("R4", "set on match", wave, 1);
    ticks(6);
    check("R4", "set again stays 1", wave, 1);
    write_reg(2'd2, 8'h02);
    ack_all();
    ticks(6);
    check("R4", "action none holds", wave, 1);
    check("R7", "flag still set with none", cmp_flag, 1);
    write_reg(2'd2, 8'h22);
    ticks(6);
    check("R4", "clear on match", wave, 0);
  endtask

  task automatic t_force();
    do_reset();
    write_reg(2'd2, 8'h12);
    write_reg(2'd1, 8'd5);
    write_reg(2'd0, 8'd5);
    @(negedge clk); force_s = 1'b1;
    @(negedge clk); force_s = 1'b0;
    check("R6", "forced toggle", wave, 1);
    check("R6", "no flag from force", cmp_flag, 0);
    check("R6", "no clear from force", count, 5);
  endtask

  task automatic t_block();
    do_reset();
    write_reg(2'd2, 8'h10);
    write_reg(2'd1, 8'h10);
    write_reg(2'd0, 8'h10);
    ticks(1);
    check("R8", "count after blocked tick", count, 8'h11);
    check("R8", "no flag on blocked tick", cmp_flag, 0);
    check("R8", "no wave on blocked tick", wave, 0);
    write_reg(2'd0, 8'h0F);
    ticks(2);
    check("R8", "real match later", cmp_flag, 1);
    check("R8", "wave toggled by real match", wave, 1);
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h80; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_sel = 2'd3; tick = 1'b0;
    check("R8", "write beats tick", count, 8'h80);
  endtask

  task automatic t_other_mode();
    do_reset();
    write_reg(2'd2, 8'h03);
    write_reg(2'd1, 8'd5);
    write_reg(2'd0, 8'd0);
    ticks(10);
    check("R10", "mode 3 does not clear", count, 10);
    check("R10", "mode 3 still matches", cmp_flag, 1);
  endtask

  task automatic t_ack_race();
    do_reset();
    write_reg(2'd2, 8'h02);
    write_reg(2'd1, 8'd5);
    write_reg(2'd0, 8'd0);
    ticks(5);
    @(negedge clk); tick = 1'b1; ack_cmp = 1'b1;
    @(negedge clk); tick = 1'b0; ack_cmp = 1'b0;
    check("R7", "set wins over ack", cmp_flag, 1);
    ack_all();
    check("R7", "ack clears", cmp_flag, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_normal_wrap();
    t_hold();
    t_ctc();
    t_actions();
    t_force();
    t_block();
    t_other_mode();
    t_ack_race();
    finish_run();
  end
endmodule